// File: doc/BRIEF.md
# Wavelet Packet Memory Address Sequencer

This block is the control unit for a three-level, four-tap wavelet packet decomposition. The arithmetic is done by three level processors, each holding a high-pass and a low-pass filter that run side by side. Intermediate coefficients are stored in three banked memories. The sequencer owns a free-running cycle counter and turns its value into the complete access schedule for those memories:

- write strobes and write pointers;
- read addresses, one per filter tap;
- processor start strobes and source selects;
- a strobe that marks when a final-level band pair is ready.

The level-1 and level-2 memories are split into a high-pass half and a low-pass half. Each half has its own write pointer, so both filter results of one processor pass land in the same cycle. Level-2 reads use a stride of two words, because two parent streams are interleaved in each half.

The schedule repeats every 32 cycles. It accepts one input sample every 2 cycles, and every processor finishes a pass every 4 cycles. Cycle c is split into a 4-cycle window w = c div 4 and a tap index k = c mod 4.

Top module: `wpas_seq`

## Requirements
- R1: The cycle output `cyc` counts 0,1,...,31 and then wraps to 0, advancing by one on every clock edge that is not in reset.
- R2: `l0_we` is 1 exactly in cycles with even c. `l0_wa` advances by one, modulo 4, after each such write, so in cycle c it equals ceil(c/2) mod 4.
- R3: `p0_go` is 1 exactly when k = 0. `l0_ra` reads tap k of the newest sample pair, at address (2w - 1 - k) mod 4.
- R4: `l1_we` is 1 exactly when k = 3. The two level-1 write pointers `l1_wa_hi` and `l1_wa_lo` advance together after each write and equal w mod 4.
- R5: `p1_go` is 1 exactly when k = 0. `p1_src` is 0 (high-pass half) in even windows and 1 (low-pass half) in odd windows. The selected half's read address is (w - 1 - k) mod 4, and the other half's read address is 0.
- R6: `l2_we` is 1 exactly when k = 3. The level-2 write pointers `l2_wa_odd` and `l2_wa_even` advance together after each write and equal w mod 8.
- R7: `p2_go` is 1 exactly when k = 0.
  - `p2_pair` = 3 - (w mod 4), so the final band pairs 7/6, 5/4, 3/2 and 1/0 come out in that order, 4 cycles apart.
  - `p2_half` = w mod 2, where 0 is the odd-band half.
  - The selected half's read address is (v - 2k) mod 8, with v = w - 2 when bits 0 and 1 of w are equal and v = w - 1 otherwise.
  - The other half's read address is 0.
- R8: `fin_we` is 1 exactly when k = 3, which ends each level-2 processor pass.
- R9: While `rst` is 1 at a clock edge, the counter and every write pointer go to 0. The first cycle after reset is cycle 0, which carries an input write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc | output | 5 | Current schedule cycle |
| l0_we | output | 1 | Level-0 memory write strobe (input sample) |
| l0_wa | output | 2 | Level-0 write pointer |
| l0_ra | output | 2 | Level-0 read address |
| p0_go | output | 1 | Level-0 processor pass start |
| l1_we | output | 1 | Level-1 memory write strobe |
| l1_wa_hi | output | 2 | Level-1 high-pass half write pointer |
| l1_wa_lo | output | 2 | Level-1 low-pass half write pointer |
| l1_ra_hi | output | 2 | Level-1 high-pass half read address |
| l1_ra_lo | output | 2 | Level-1 low-pass half read address |
| p1_go | output | 1 | Level-1 processor pass start |
| p1_src | output | 1 | Level-1 source half (0 high-pass, 1 low-pass) |
| l2_we | output | 1 | Level-2 memory write strobe |
| l2_wa_odd | output | 3 | Level-2 odd-band half write pointer |
| l2_wa_even | output | 3 | Level-2 even-band half write pointer |
| l2_ra_odd | output | 3 | Level-2 odd-band half read address |
| l2_ra_even | output | 3 | Level-2 even-band half read address |
| p2_go | output | 1 | Level-2 processor pass start |
| p2_half | output | 1 | Level-2 source half (0 odd-band, 1 even-band) |
| p2_pair | output | 2 | Final band pair index being produced |
| fin_we | output | 1 | Final band pair write strobe |

## Verification
The riskiest corner is window 0. There the level-2 newest-entry index v is negative (-2), and the level-0 and level-1 read addresses also go below zero. A design that computes these without modulo wrap would read the wrong words at the start of every period.

The 31-to-0 wrap of the counter must not disturb the write pointers. A wrong pointer width or wrap would break the second period, so the bench compares every output against an independent model for two periods.

A reset in the middle of a period must restart the counter and all pointers at zero. A design that cleared only the counter would leave the write pointers out of phase with the schedule.

The stride-two level-2 read and the reversed band-pair order are also checked in every window. A swapped parity would make the processor mix two parent streams.

// File: rtl/wpas_pkg.sv
package wpas_pkg;
    parameter int LEVELS = 3;
    parameter int TAPS   = 4;

    localparam int PERIOD = ((1 << LEVELS) * TAPS * TAPS) / 4;
    localparam int CW     = $clog2(PERIOD);
    localparam int TW     = $clog2(TAPS);
    localparam int WW     = CW - TW;
    localparam int A0W    = $clog2(TAPS);
    localparam int A1W    = $clog2(TAPS);
    localparam int A2W    = $clog2(2 * TAPS);

    typedef struct packed {
        logic [WW-1:0] win;
        logic [TW-1:0] tap;
    } phase_t;

    typedef struct packed {
        logic           p0_go;
        logic [A0W-1:0] l0_ra;
        logic           p1_go;
        logic           p1_src;
        logic [A1W-1:0] l1_ra_hi;
        logic [A1W-1:0] l1_ra_lo;
        logic           p2_go;
        logic           p2_half;
        logic [1:0]     p2_pair;
        logic [A2W-1:0] l2_ra_odd;
        logic [A2W-1:0] l2_ra_even;
    } rd_bus_t;

    function automatic phase_t split_cycle(input logic [CW-1:0] c);
        phase_t p;
        p.win = c[CW-1:TW];
        p.tap = c[TW-1:0];
        return p;
    endfunction

    function automatic logic last_tap(input logic [TW-1:0] t);
        return t == TW'(TAPS - 1);
    endfunction
endpackage

// File: rtl/wpas_cycle_ctr.sv
module wpas_cycle_ctr
    import wpas_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] cyc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cyc <= '0;
        end else if (cyc == CW'(PERIOD - 1)) begin
            cyc <= '0;
        end else begin
            cyc <= cyc + CW'(1);
        end
    end
endmodule

// File: rtl/wpas_wr_ptr.sv
module wpas_wr_ptr #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    output logic [W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (we) begin
            ptr <= ptr + W'(1);
        end
    end
endmodule

// File: rtl/wpas_rd_gen.sv
module wpas_rd_gen
    import wpas_pkg::*;
(
    input  logic [CW-1:0] cyc,
    output rd_bus_t       rd
);
    phase_t        ph;
    logic [CW-1:0] t0;
    logic [CW-1:0] t1;
    logic [WW-1:0] newest2;
    logic [CW-1:0] t2;
    logic          same_par;

    always_comb begin
        ph = split_cycle(cyc);

        // level 0: stride-one taps back from the newest odd sample
        t0 = CW'({ph.win, 1'b0}) - CW'(1) - CW'(ph.tap);

        // level 1: one half per window, taps back from the last pair written
        t1 = CW'(ph.win) - CW'(1) - CW'(ph.tap);

        // level 2: pick newest entry of the wanted source parity, stride two
        same_par = ph.win[0] == ph.win[1];
        newest2  = ph.win - WW'(1) - WW'(same_par);
        t2       = CW'(newest2) - CW'({ph.tap, 1'b0});

        rd.p0_go      = ph.tap == '0;
        rd.l0_ra      = t0[A0W-1:0];

        rd.p1_go      = ph.tap == '0;
        rd.p1_src     = ph.win[0];
        rd.l1_ra_hi   = ph.win[0] ? '0 : t1[A1W-1:0];
        rd.l1_ra_lo   = ph.win[0] ? t1[A1W-1:0] : '0;

        rd.p2_go      = ph.tap == '0;
        rd.p2_half    = ph.win[0];
        rd.p2_pair    = 2'd3 - ph.win[1:0];
        rd.l2_ra_odd  = ph.win[0] ? '0 : t2[A2W-1:0];
        rd.l2_ra_even = ph.win[0] ? t2[A2W-1:0] : '0;
    end
endmodule

// File: rtl/wpas_seq.sv
module wpas_seq
    import wpas_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    output logic [CW-1:0]  cyc,
    output logic           l0_we,
    output logic [A0W-1:0] l0_wa,
    output logic [A0W-1:0] l0_ra,
    output logic           p0_go,
    output logic           l1_we,
    output logic [A1W-1:0] l1_wa_hi,
    output logic [A1W-1:0] l1_wa_lo,
    output logic [A1W-1:0] l1_ra_hi,
    output logic [A1W-1:0] l1_ra_lo,
    output logic           p1_go,
    output logic           p1_src,
    output logic           l2_we,
    output logic [A2W-1:0] l2_wa_odd,
    output logic [A2W-1:0] l2_wa_even,
    output logic [A2W-1:0] l2_ra_odd,
    output logic [A2W-1:0] l2_ra_even,
    output logic           p2_go,
    output logic           p2_half,
    output logic [1:0]     p2_pair,
    output logic           fin_we
);
    phase_t  ph;
    rd_bus_t rd;
    logic [1:0][A1W-1:0] l1_ptr;
    logic [1:0][A2W-1:0] l2_ptr;

    wpas_cycle_ctr i_ctr (.clk(clk), .rst(rst), .cyc(cyc));

    assign ph     = split_cycle(cyc);
    assign l0_we  = ~cyc[0];
    assign l1_we  = last_tap(ph.tap);
    assign l2_we  = last_tap(ph.tap);
    assign fin_we = last_tap(ph.tap);

    wpas_wr_ptr #(.W(A0W)) i_wp0 (.clk(clk), .rst(rst), .we(l0_we), .ptr(l0_wa));

    for (genvar h = 0; h < 2; h++) begin : g_half
        wpas_wr_ptr #(.W(A1W)) i_wp1 (.clk(clk), .rst(rst), .we(l1_we), .ptr(l1_ptr[h]));
        wpas_wr_ptr #(.W(A2W)) i_wp2 (.clk(clk), .rst(rst), .we(l2_we), .ptr(l2_ptr[h]));
    end

    assign l1_wa_hi   = l1_ptr[0];
    assign l1_wa_lo   = l1_ptr[1];
    assign l2_wa_odd  = l2_ptr[0];
    assign l2_wa_even = l2_ptr[1];

    wpas_rd_gen i_rd (.cyc(cyc), .rd(rd));

    assign p0_go      = rd.p0_go;
    assign l0_ra      = rd.l0_ra;
    assign p1_go      = rd.p1_go;
    assign p1_src     = rd.p1_src;
    assign l1_ra_hi   = rd.l1_ra_hi;
    assign l1_ra_lo   = rd.l1_ra_lo;
    assign p2_go      = rd.p2_go;
    assign p2_half    = rd.p2_half;
    assign p2_pair    = rd.p2_pair;
    assign l2_ra_odd  = rd.l2_ra_odd;
    assign l2_ra_even = rd.l2_ra_even;
endmodule

// File: rtl/wpas_chk.sv
module wpas_chk
    import wpas_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [CW-1:0]  cyc,
    input logic           l0_we,
    input logic [A0W-1:0] l0_wa,
    input logic           l1_we,
    input logic [A1W-1:0] l1_wa_hi,
    input logic [A1W-1:0] l1_wa_lo,
    input logic           l2_we,
    input logic [A2W-1:0] l2_wa_odd,
    input logic           p2_go,
    input logic [1:0]     p2_pair,
    input logic           fin_we
);
    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        cyc == CW'(PERIOD - 1) |=> cyc == '0);
    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        cyc != CW'(PERIOD - 1) |=> cyc == $past(cyc) + CW'(1));
    a_r2_alternate: assert property (@(posedge clk) disable iff (rst)
        l0_we |=> !l0_we);
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (rst)
        l0_we |=> l0_wa == $past(l0_wa) + A0W'(1));
    a_r4_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        !l1_we |=> $stable(l1_wa_hi) && $stable(l1_wa_lo));
    a_r4_halves_equal: assert property (@(posedge clk) disable iff (rst)
        l1_wa_hi == l1_wa_lo);
    a_r6_ptr_step: assert property (@(posedge clk) disable iff (rst)
        l2_we |=> l2_wa_odd == $past(l2_wa_odd) + A2W'(1));
    a_r7_pair_hold: assert property (@(posedge clk) disable iff (rst)
        !p2_go |-> $stable(p2_pair));
    a_r8_start_end_apart: assert property (@(posedge clk) disable iff (rst)
        $onehot0({p2_go, fin_we}));
endmodule

bind wpas_seq wpas_chk i_chk (
    .clk(clk), .rst(rst), .cyc(cyc), .l0_we(l0_we), .l0_wa(l0_wa),
    .l1_we(l1_we), .l1_wa_hi(l1_wa_hi), .l1_wa_lo(l1_wa_lo),
    .l2_we(l2_we), .l2_wa_odd(l2_wa_odd), .p2_go(p2_go),
    .p2_pair(p2_pair), .fin_we(fin_we)
);

// File: tb/test_wpas_seq.sv
module test_wpas_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] cyc;
    logic       l0_we, p0_go, l1_we, p1_go, p1_src, l2_we, p2_go, p2_half, fin_we;
    logic [1:0] l0_wa, l0_ra, l1_wa_hi, l1_wa_lo, l1_ra_hi, l1_ra_lo, p2_pair;
    logic [2:0] l2_wa_odd, l2_wa_even, l2_ra_odd, l2_ra_even;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wpas_seq i_wpas_seq (
        .clk(clk), .rst(rst), .cyc(cyc), .l0_we(l0_we), .l0_wa(l0_wa),
        .l0_ra(l0_ra), .p0_go(p0_go), .l1_we(l1_we), .l1_wa_hi(l1_wa_hi),
        .l1_wa_lo(l1_wa_lo), .l1_ra_hi(l1_ra_hi), .l1_ra_lo(l1_ra_lo),
        .p1_go(p1_go), .p1_src(p1_src), .l2_we(l2_we), .l2_wa_odd(l2_wa_odd),
        .l2_wa_even(l2_wa_even), .l2_ra_odd(l2_ra_odd), .l2_ra_even(l2_ra_even),
        .p2_go(p2_go), .p2_half(p2_half), .p2_pair(p2_pair), .fin_we(fin_we)
    );

    function automatic int md(input int x, input int m);
        return ((x % m) + m) % m;
    endfunction

    task automatic chk(input string tag, input int c, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, c, act, exp);
        end
    endtask

    // compare all outputs against the schedule model for cycle c
    task automatic check_cycle(input int c);
        int w, k, r1, v, r2, half, par;
        w = c / 4; k = c % 4;
        half = w % 2; par = (w / 2) % 2;
        r1 = md(w - 1 - k, 4);
        v  = w - 1 - ((half == par) ? 1 : 0);
        r2 = md(v - 2 * k, 8);
        chk("R1", c, int'(cyc), c);
        chk("R2", c, int'({l0_we, l0_wa}), ((c % 2 == 0) ? 4 : 0) + md((c + 1) / 2, 4));
        chk("R3", c, int'({p0_go, l0_ra}), ((k == 0) ? 4 : 0) + md(2 * w - 1 - k, 4));
        chk("R4", c, int'({l1_we, l1_wa_hi, l1_wa_lo}),
            ((k == 3) ? 16 : 0) + (w % 4) * 4 + (w % 4));
        chk("R5", c, int'({p1_go, p1_src, l1_ra_hi, l1_ra_lo}),
            ((k == 0) ? 32 : 0) + half * 16 + ((half == 0) ? r1 * 4 : r1));
        chk("R6", c, int'({l2_we, l2_wa_odd, l2_wa_even}),
            ((k == 3) ? 64 : 0) + (w % 8) * 8 + (w % 8));
        chk("R7", c, int'({p2_go, p2_half, p2_pair, l2_ra_odd, l2_ra_even}),
            ((k == 0) ? 512 : 0) + half * 256 + (3 - (w % 4)) * 64 +
            ((half == 0) ? r2 * 8 : r2));
        chk("R8", c, int'(fin_we), (k == 3) ? 1 : 0);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk("R9", 0, int'({cyc, l0_wa, l1_wa_hi, l1_wa_lo, l2_wa_odd, l2_wa_even}), 0);
        rst = 1'b0;
        check_cycle(0);
    endtask

    task automatic t_periods(input int n);
        for (int i = 1; i < n * 32; i++) begin
            @(negedge clk);
            check_cycle(i % 32);
        end
    endtask

    task automatic t_mid_reset();
        for (int i = 1; i <= 13; i++) begin
            @(negedge clk);
            check_cycle(i);
        end
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R9", 99, int'({cyc, l0_wa, l1_wa_hi, l1_wa_lo, l2_wa_odd, l2_wa_even}), 0);
        rst = 1'b0;
        check_cycle(0);
        t_periods(1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset_state();
        t_periods(2);
        @(negedge clk);
        check_cycle(0);
        t_mid_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule